// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block is the operand-bypass and pipeline-squash decision logic for a five-stage in-order integer core. Each cycle it looks at the two source register numbers of the instruction sitting in decode and compares them against the destination numbers and write enables held in the execute, memory and writeback pipeline registers. From those comparisons it picks, for each of three operand paths (first ALU operand, second ALU operand, and the register value that stores and branches carry forward), which stage should supply the value. The register file is the fallback.

It also decides how the front of the pipeline moves. A load in execute whose result is needed in decode freezes fetch and decode for one cycle and sends a bubble into execute. A redirect of the next PC squashes the two younger instructions. An excepting instruction that has reached the memory boundary turns into a bubble there, unless it is a plain breakpoint still in execute. Every output is combinational from the present pipeline-register state.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each forward select uses the code 0 = register file, 1 = execute stage, 2 = memory stage, 3 = writeback stage. When more than one stage qualifies, execute wins over memory and memory wins over writeback.
- R2: A stage qualifies as a source only if three conditions all hold: its destination number equals the source number, that destination is not register 0, and its write enable is set.
- R3: The memory-stage write enable used for matching is `mm_wen` with `mm_fault` masked out. A faulting memory access never forwards. The masked enable is also driven on `mm_wen_eff`.
- R4: The first-operand select is active only when `dec_rs1_used` is set. The second-operand select is active only when `dec_op2_is_reg` is set. The carried-rs2 select is active only when `dec_rs2_used` is set. All three otherwise read 0.
- R5: A load-use hazard exists when `ex_is_load` is set, `ex_rd` is nonzero, and `ex_rd` equals a used rs1 or a used rs2. With no redirect present, the hazard raises `if_stall`, `id_stall` and `ex_bubble`.
- R6: When `nextpc_sel` is not 0 (0 means sequential PC+4), both `id_bubble` and `ex_bubble` are raised, and the stalls are held low in that cycle.
- R7: `mm_bubble` is raised when `mm_exc` is nonzero. It is also raised when `ex_exc` is nonzero and not exactly the breakpoint code, which is the single bit `BRK_BIT` (bit 3 by default).
- R8: `id_stall` and `id_bubble` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | AW | First source register number in decode |
| dec_rs2 | input | AW | Second source register number in decode |
| dec_rs1_used | input | 1 | Decode instruction reads its first source |
| dec_rs2_used | input | 1 | Decode instruction reads its second source |
| dec_op2_is_reg | input | 1 | Second ALU operand comes from a register, not an immediate |
| ex_rd | input | AW | Destination number in execute |
| ex_wen | input | 1 | Register write enable in execute |
| ex_is_load | input | 1 | Execute instruction is a load |
| mm_rd | input | AW | Destination number in memory stage |
| mm_wen | input | 1 | Register write enable in memory stage, before fault masking |
| mm_fault | input | 1 | Data access fault in the memory stage |
| wb_rd | input | AW | Destination number in writeback |
| wb_wen | input | 1 | Register write enable in writeback |
| nextpc_sel | input | PCS_W | Next-PC choice resolved in execute, 0 = sequential |
| ex_exc | input | EXC_W | Exception flags carried in execute |
| mm_exc | input | EXC_W | Exception flags carried in memory stage |
| fwd_op1_sel | output | 2 | Source select for first ALU operand |
| fwd_op2_sel | output | 2 | Source select for second ALU operand |
| fwd_rs2_sel | output | 2 | Source select for carried rs2 value |
| mm_wen_eff | output | 1 | Memory-stage write enable after fault masking |
| if_stall | output | 1 | Hold the fetch PC |
| id_stall | output | 1 | Hold the decode register |
| id_bubble | output | 1 | Load a bubble into decode |
| ex_bubble | output | 1 | Load a bubble into execute |
| mm_bubble | output | 1 | Load a bubble into the memory stage |

## Verification
Directed patterns cover the key cases one at a time. One pattern has all three later stages targeting the same register, and the enables are then dropped one by one; this separates the priority order from a plain match. Other patterns use destination zero, a faulting memory access, an immediate second operand while rs2 is still used, and a load-use hazard that coincides with a redirect; each of these isolates one gating term. After the directed cases, several thousand biased random vectors confine register numbers to a tiny range so that multi-stage matches and exception mixes are frequent. A behavioural model checks every output against these vectors on each clock.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic [1:0] {
      FWD_NONE = 2'd0,
      FWD_EX   = 2'd1,
      FWD_MM   = 2'd2,
      FWD_WB   = 2'd3
   } fwd_sel_e;

   localparam int NUM_PATHS = 3;
   localparam int PATH_OP1  = 0;
   localparam int PATH_OP2  = 1;
   localparam int PATH_RS2  = 2;
endpackage

// File: rtl/phc_src_match.sv
module phc_src_match
   import phc_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic          src_en,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic [AW-1:0] mm_rd,
   input  logic          mm_wen,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   output fwd_sel_e      sel
);
   logic hit_ex, hit_mm, hit_wb;

   assign hit_ex = src_en && ex_wen && (ex_rd != '0) && (ex_rd == src);
   assign hit_mm = src_en && mm_wen && (mm_rd != '0) && (mm_rd == src);
   assign hit_wb = src_en && wb_wen && (wb_rd != '0) && (wb_rd == src);

   always_comb begin
      if (hit_ex)      sel = FWD_EX;
      else if (hit_mm) sel = FWD_MM;
      else if (hit_wb) sel = FWD_WB;
      else             sel = FWD_NONE;
   end
endmodule

// File: rtl/phc_load_use.sv
module phc_load_use #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] dec_rs1,
   input  logic [AW-1:0] dec_rs2,
   input  logic          dec_rs1_used,
   input  logic          dec_rs2_used,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_is_load,
   output logic          hazard
);
   logic dep_rs1, dep_rs2;

   assign dep_rs1 = dec_rs1_used && (ex_rd == dec_rs1);
   assign dep_rs2 = dec_rs2_used && (ex_rd == dec_rs2);
   assign hazard  = ex_is_load && (ex_rd != '0) && (dep_rs1 || dep_rs2);
endmodule

// File: rtl/phc_squash.sv
module phc_squash #(
   parameter int EXC_W   = 4,
   parameter int BRK_BIT = 3,
   parameter int PCS_W   = 2
) (
   input  logic             load_use,
   input  logic [PCS_W-1:0] nextpc_sel,
   input  logic [EXC_W-1:0] ex_exc,
   input  logic [EXC_W-1:0] mm_exc,
   output logic             if_stall,
   output logic             id_stall,
   output logic             id_bubble,
   output logic             ex_bubble,
   output logic             mm_bubble
);
   localparam logic [EXC_W-1:0] BRK_CODE = EXC_W'(1) << BRK_BIT;

   logic redirect, ex_kill, hold;

   assign redirect  = (nextpc_sel != '0);
   assign ex_kill   = (ex_exc != '0) && (ex_exc != BRK_CODE);
   // a redirect squashes the stalled instruction anyway, so it takes priority
   assign hold      = load_use && !redirect;

   assign if_stall  = hold;
   assign id_stall  = hold;
   assign id_bubble = redirect;
   assign ex_bubble = load_use || redirect;
   assign mm_bubble = ex_kill || (mm_exc != '0);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import phc_pkg::*;
#(
   parameter int AW      = 5,
   parameter int EXC_W   = 4,
   parameter int BRK_BIT = 3,
   parameter int PCS_W   = 2
) (
   input  logic [AW-1:0]    dec_rs1,
   input  logic [AW-1:0]    dec_rs2,
   input  logic             dec_rs1_used,
   input  logic             dec_rs2_used,
   input  logic             dec_op2_is_reg,
   input  logic [AW-1:0]    ex_rd,
   input  logic             ex_wen,
   input  logic             ex_is_load,
   input  logic [AW-1:0]    mm_rd,
   input  logic             mm_wen,
   input  logic             mm_fault,
   input  logic [AW-1:0]    wb_rd,
   input  logic             wb_wen,
   input  logic [PCS_W-1:0] nextpc_sel,
   input  logic [EXC_W-1:0] ex_exc,
   input  logic [EXC_W-1:0] mm_exc,
   output logic [1:0]       fwd_op1_sel,
   output logic [1:0]       fwd_op2_sel,
   output logic [1:0]       fwd_rs2_sel,
   output logic             mm_wen_eff,
   output logic             if_stall,
   output logic             id_stall,
   output logic             id_bubble,
   output logic             ex_bubble,
   output logic             mm_bubble
);
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end
   if (BRK_BIT < 0 || BRK_BIT >= EXC_W) begin : g_bad_brk
      $error("BRK_BIT must lie inside the exception field");
   end
   if (PCS_W < 1) begin : g_bad_pcs
      $error("PCS_W must be at least 1");
   end

   logic [AW-1:0] path_src [NUM_PATHS];
   logic          path_en  [NUM_PATHS];
   fwd_sel_e      path_sel [NUM_PATHS];
   logic          load_use;

   assign mm_wen_eff = mm_wen && !mm_fault;

   assign path_src[PATH_OP1] = dec_rs1;
   assign path_en [PATH_OP1] = dec_rs1_used;
   assign path_src[PATH_OP2] = dec_rs2;
   assign path_en [PATH_OP2] = dec_op2_is_reg;
   assign path_src[PATH_RS2] = dec_rs2;
   assign path_en [PATH_RS2] = dec_rs2_used;

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      phc_src_match #(.AW(AW)) u_match (
         .src    (path_src[p]),
         .src_en (path_en[p]),
         .ex_rd  (ex_rd),
         .ex_wen (ex_wen),
         .mm_rd  (mm_rd),
         .mm_wen (mm_wen_eff),
         .wb_rd  (wb_rd),
         .wb_wen (wb_wen),
         .sel    (path_sel[p])
      );
   end

   assign fwd_op1_sel = path_sel[PATH_OP1];
   assign fwd_op2_sel = path_sel[PATH_OP2];
   assign fwd_rs2_sel = path_sel[PATH_RS2];

   phc_load_use #(.AW(AW)) u_load_use (
      .dec_rs1      (dec_rs1),
      .dec_rs2      (dec_rs2),
      .dec_rs1_used (dec_rs1_used),
      .dec_rs2_used (dec_rs2_used),
      .ex_rd        (ex_rd),
      .ex_is_load   (ex_is_load),
      .hazard       (load_use)
   );

   phc_squash #(.EXC_W(EXC_W), .BRK_BIT(BRK_BIT), .PCS_W(PCS_W)) u_squash (
      .load_use   (load_use),
      .nextpc_sel (nextpc_sel),
      .ex_exc     (ex_exc),
      .mm_exc     (mm_exc),
      .if_stall   (if_stall),
      .id_stall   (id_stall),
      .id_bubble  (id_bubble),
      .ex_bubble  (ex_bubble),
      .mm_bubble  (mm_bubble)
   );
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
   parameter int AW      = 5,
   parameter int EXC_W   = 4,
   parameter int BRK_BIT = 3,
   parameter int PCS_W   = 2
) (
   input logic [AW-1:0]    dec_rs1,
   input logic [AW-1:0]    dec_rs2,
   input logic             dec_rs1_used,
   input logic             dec_rs2_used,
   input logic             dec_op2_is_reg,
   input logic [AW-1:0]    ex_rd,
   input logic             ex_wen,
   input logic             ex_is_load,
   input logic [AW-1:0]    mm_rd,
   input logic             mm_wen,
   input logic             mm_fault,
   input logic [AW-1:0]    wb_rd,
   input logic             wb_wen,
   input logic [PCS_W-1:0] nextpc_sel,
   input logic [EXC_W-1:0] ex_exc,
   input logic [EXC_W-1:0] mm_exc,
   input logic [1:0]       fwd_op1_sel,
   input logic [1:0]       fwd_op2_sel,
   input logic [1:0]       fwd_rs2_sel,
   input logic             mm_wen_eff,
   input logic             if_stall,
   input logic             id_stall,
   input logic             id_bubble,
   input logic             ex_bubble,
   input logic             mm_bubble
);
   always_comb begin
      assert_no_stall_bubble_R8 : assert (!(id_stall && id_bubble))
         else $error("decode stalled and bubbled together");
      assert_ex_src_valid_R2 : assert (fwd_op1_sel != 2'd1 ||
         (dec_rs1_used && ex_wen && ex_rd != '0 && ex_rd == dec_rs1))
         else $error("execute forward on op1 without a qualifying match");
      assert_fault_no_fwd_R3 : assert (!mm_fault ||
         (fwd_op1_sel != 2'd2 && fwd_op2_sel != 2'd2 && fwd_rs2_sel != 2'd2 && !mm_wen_eff))
         else $error("faulting memory stage used as a forward source");
      assert_imm_op2_R4 : assert (dec_op2_is_reg || fwd_op2_sel == 2'd0)
         else $error("op2 forwarded for an immediate operand");
      assert_stall_pair_R5 : assert (if_stall == id_stall && (!if_stall || (ex_bubble && ex_is_load)))
         else $error("load-use stall controls inconsistent");
      assert_redirect_R6 : assert (nextpc_sel == '0 || (id_bubble && ex_bubble && !if_stall))
         else $error("redirect did not squash decode and execute");
      assert_mm_exc_R7 : assert (mm_exc == '0 || mm_bubble)
         else $error("memory-stage exception not bubbled");
   end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
   .AW(AW), .EXC_W(EXC_W), .BRK_BIT(BRK_BIT), .PCS_W(PCS_W)
) u_chk (.*);

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int EXC_W = 4;
   localparam int BRK_BIT = 3;
   localparam int PCS_W = 2;
   localparam int N_RANDOM = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0]    dec_rs1, dec_rs2, ex_rd, mm_rd, wb_rd;
   logic             dec_rs1_used, dec_rs2_used, dec_op2_is_reg;
   logic             ex_wen, ex_is_load, mm_wen, mm_fault, wb_wen;
   logic [PCS_W-1:0] nextpc_sel;
   logic [EXC_W-1:0] ex_exc, mm_exc;
   logic [1:0]       fwd_op1_sel, fwd_op2_sel, fwd_rs2_sel;
   logic             mm_wen_eff, if_stall, id_stall, id_bubble, ex_bubble, mm_bubble;

   int n_checks = 0;
   int n_fails  = 0;

   pipe_hazard_ctrl #(.AW(AW), .EXC_W(EXC_W), .BRK_BIT(BRK_BIT), .PCS_W(PCS_W)) uut (.*);

   function automatic int pick(int src, bit en, bit mwen);
      // priority: execute, then memory, then writeback, else register file
      if (!en) return 0;
      if (ex_wen && ex_rd != 0 && int'(ex_rd) == src) return 1;
      if (mwen && mm_rd != 0 && int'(mm_rd) == src) return 2;
      if (wb_wen && wb_rd != 0 && int'(wb_rd) == src) return 3;
      return 0;
   endfunction

   task automatic check(string tag, string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, tag, act, exp);
      end
   endtask

   task automatic compare(string tag);
      bit mwen, lu, redir, exk;
      int e_if, e_idb, e_exb, e_mmb;
      mwen  = mm_wen && !mm_fault;
      lu    = ex_is_load && ex_rd != 0 &&
              ((dec_rs1_used && ex_rd == dec_rs1) || (dec_rs2_used && ex_rd == dec_rs2));
      redir = (nextpc_sel != 0);
      exk   = (ex_exc != 0) && (int'(ex_exc) != (1 << BRK_BIT));
      e_if  = (lu && !redir) ? 1 : 0;
      e_idb = redir ? 1 : 0;
      e_exb = (lu || redir) ? 1 : 0;
      e_mmb = (exk || mm_exc != 0) ? 1 : 0;
      check(tag, "R1", "fwd_op1_sel", int'(fwd_op1_sel), pick(int'(dec_rs1), dec_rs1_used, mwen));
      check(tag, "R4", "fwd_op2_sel", int'(fwd_op2_sel), pick(int'(dec_rs2), dec_op2_is_reg, mwen));
      check(tag, "R4", "fwd_rs2_sel", int'(fwd_rs2_sel), pick(int'(dec_rs2), dec_rs2_used, mwen));
      check(tag, "R3", "mm_wen_eff", int'(mm_wen_eff), int'(mwen));
      check(tag, "R5", "if_stall", int'(if_stall), e_if);
      check(tag, "R5", "id_stall", int'(id_stall), e_if);
      check(tag, "R6", "id_bubble", int'(id_bubble), e_idb);
      check(tag, "R6", "ex_bubble", int'(ex_bubble), e_exb);
      check(tag, "R7", "mm_bubble", int'(mm_bubble), e_mmb);
      check(tag, "R8", "stall_and_bubble", int'(id_stall && id_bubble), 0);
   endtask

   task automatic clear_inputs();
      dec_rs1 = '0; dec_rs2 = '0; dec_rs1_used = 0; dec_rs2_used = 0; dec_op2_is_reg = 0;
      ex_rd = '0; ex_wen = 0; ex_is_load = 0; mm_rd = '0; mm_wen = 0; mm_fault = 0;
      wb_rd = '0; wb_wen = 0; nextpc_sel = '0; ex_exc = '0; mm_exc = '0;
   endtask

   task automatic step(string tag);
      @(negedge clk);
      compare(tag);
      @(posedge clk);
      #1;
   endtask

   initial begin
      clear_inputs();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      #1;
      step("reset state");
      check("reset", "R1", "op1 idle", int'(fwd_op1_sel), 0);

      // R1: all three stages write r5
      dec_rs1 = 5; dec_rs1_used = 1;
      ex_rd = 5; ex_wen = 1; mm_rd = 5; mm_wen = 1; wb_rd = 5; wb_wen = 1;
      step("R1 all match");
      check("R1 all match", "R1", "op1 from execute", int'(fwd_op1_sel), 1);
      ex_wen = 0;
      step("R1 mm wins");
      check("R1 mm wins", "R1", "op1 from memory", int'(fwd_op1_sel), 2);
      mm_wen = 0;
      step("R1 wb only");
      check("R1 wb only", "R1", "op1 from writeback", int'(fwd_op1_sel), 3);

      // R2: register zero never forwards
      clear_inputs();
      dec_rs1_used = 1; ex_wen = 1; mm_wen = 1; wb_wen = 1;
      step("R2 x0");
      check("R2 x0", "R2", "op1 x0", int'(fwd_op1_sel), 0);

      // R3: faulting memory access
      clear_inputs();
      dec_rs1 = 7; dec_rs1_used = 1; mm_rd = 7; mm_wen = 1; mm_fault = 1; wb_rd = 7; wb_wen = 1;
      step("R3 fault");
      check("R3 fault", "R3", "op1 skips faulting mm", int'(fwd_op1_sel), 3);
      check("R3 fault", "R3", "mm_wen_eff", int'(mm_wen_eff), 0);

      // R4: immediate op2 while rs2 still used
      clear_inputs();
      dec_rs2 = 9; dec_rs2_used = 1; dec_op2_is_reg = 0; ex_rd = 9; ex_wen = 1;
      step("R4 imm op2");
      check("R4 imm op2", "R4", "op2 gated", int'(fwd_op2_sel), 0);
      check("R4 imm op2", "R4", "rs2 forwarded", int'(fwd_rs2_sel), 1);

      // R5: load-use on rs2
      clear_inputs();
      dec_rs2 = 4; dec_rs2_used = 1; ex_rd = 4; ex_wen = 1; ex_is_load = 1;
      step("R5 load use");
      check("R5 load use", "R5", "if_stall", int'(if_stall), 1);
      check("R5 load use", "R5", "ex_bubble", int'(ex_bubble), 1);

      // R6 with R8: redirect coinciding with a load-use hazard
      nextpc_sel = 2'd2;
      step("R6 redirect+load");
      check("R6 redirect+load", "R8", "id_stall suppressed", int'(id_stall), 0);
      check("R6 redirect+load", "R6", "id_bubble", int'(id_bubble), 1);

      // R7: breakpoint alone in execute does not bubble
      clear_inputs();
      ex_exc = 4'b1000;
      step("R7 brk ex");
      check("R7 brk ex", "R7", "brk exempt", int'(mm_bubble), 0);
      ex_exc = 4'b1001;
      step("R7 brk+other");
      check("R7 brk+other", "R7", "mixed flags", int'(mm_bubble), 1);
      ex_exc = 4'b0000; mm_exc = 4'b1000;
      step("R7 brk mm");
      check("R7 brk mm", "R7", "mm any exc", int'(mm_bubble), 1);

      // random sweep with a narrow register range
      for (int i = 0; i < N_RANDOM; i++) begin
         dec_rs1 = AW'($urandom_range(0, 3)); dec_rs2 = AW'($urandom_range(0, 3));
         ex_rd = AW'($urandom_range(0, 3)); mm_rd = AW'($urandom_range(0, 3));
         wb_rd = AW'($urandom_range(0, 3));
         dec_rs1_used = 1'($urandom); dec_rs2_used = 1'($urandom); dec_op2_is_reg = 1'($urandom);
         ex_wen = 1'($urandom); ex_is_load = 1'($urandom); mm_wen = 1'($urandom);
         mm_fault = ($urandom_range(0, 3) == 0); wb_wen = 1'($urandom);
         nextpc_sel = ($urandom_range(0, 3) == 0) ? PCS_W'($urandom) : '0;
         ex_exc = ($urandom_range(0, 2) == 0) ? EXC_W'($urandom) : '0;
         mm_exc = ($urandom_range(0, 4) == 0) ? EXC_W'($urandom) : '0;
         step("random");
      end

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule